// File: doc/BRIEF.md
# Shadow Region Decoder

This block turns a handful of shadow-control register values into memory routing attributes for the upper memory area, from 0xC0000 to 0xFFFFF. The area between 0xC0000 and 0xEFFFF is cut into twelve 16 KB blocks. The top 64 KB (0xF0000 to 0xFFFFF) is one region of its own. For every block the decoder states two things: whether a read is served from on-board DRAM or from the external bus, and whether a write lands in DRAM, goes to the bus, or is dropped.

Each block's attribute is settled by a fixed priority. First come the group master enable and the per-block enable. Next comes the write-protect bit, then a global write-internal flag. The C group takes its master and protect bits from a different register than the D and E groups. The D and E groups use separate bits of a shared register.

A lookup port returns the attribute for any 20-bit address. A shadowed-region bitmap marks every block that touches DRAM. A remap decision says whether the memory hidden under this area may be moved to the top of memory, and at which megabyte. Every output is purely combinational from the inputs.

Top module: `shadow_region_decoder`

## Requirements
- R1: The F region (0xF0000–0xFFFFF) reads from the bus and writes to DRAM when `cfg_main[7]` is 1. When that bit is 0 it reads from DRAM and drops writes.
- R2: Read source is encoded 0 = bus, 1 = DRAM. Write target is encoded 2'b00 = bus, 2'b01 = DRAM, 2'b10 = dropped, and 2'b11 is never produced. Block k is at bit k of `blk_rd_dram` and bits 2k+1:2k of `blk_wr`. Blocks 0–3 start at 0xC0000 + k·16 KB, and blocks 4–11 start at 0xD0000 + (k−4)·16 KB.
- R3: When a block's group master and its own enable are both 1, it reads from DRAM. Its writes are dropped if the group write-protect is 1, and go to DRAM otherwise.
- R4: The C blocks (0–3) take their master from `cfg_c[4]`, write-protect from `cfg_c[5]` and enables from `cfg_c[3:0]`. The D blocks (4–7) take master `cfg_main[6]` and write-protect `cfg_main[4]`. The E blocks (8–11) take master `cfg_main[5]` and write-protect `cfg_main[3]`. Block k of D and E is enabled by `cfg_de_en[k−4]`.
- R5: When R3 does not apply and `cfg_c[6]` is 1, a block reads from the bus and writes to DRAM.
- R6: When neither R3 nor R5 applies, a block reads from and writes to the bus.
- R7: `shadow_map[k]` is 1 exactly when block k reads from DRAM or writes to DRAM. Bits 15:12 are always 1.
- R8: `remap_en` is 1 only when all four of these hold: `mem_size_kb` ≤ 8192, `shadow_map[11:0]` is zero, `cfg_remap[3:0]` is nonzero, and `cfg_remap[4]` is 1.
- R9: `remap_start_kb` equals `cfg_remap[3:0]`·1024 when `remap_en` is 1, and 0 otherwise.
- R10: For an address in 0xC0000–0xFFFFF, `addr_hit` is 1 and the lookup outputs equal that address's block or F attribute. Below 0xC0000, `addr_hit` is 0 and the lookup reports bus read and bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_remap | input | 8 | Remap control: [3:0] start in MB, [4] remap allow |
| cfg_main | input | 8 | F-region mode [7], D/E masters [6]/[5], D/E write-protect [4]/[3] |
| cfg_de_en | input | 8 | Per-block enables for D and E blocks |
| cfg_c | input | 8 | C enables [3:0], C master [4], C write-protect [5], global write-internal [6] |
| mem_size_kb | input | 16 | Installed memory in KB |
| lookup_addr | input | 20 | Address to classify |
| blk_rd_dram | output | 12 | Per-block read source |
| blk_wr | output | 24 | Per-block write target, two bits per block |
| f_rd_dram | output | 1 | F region read source |
| f_wr | output | 2 | F region write target |
| shadow_map | output | 16 | Shadowed-region bitmap |
| remap_en | output | 1 | Top-of-memory remap allowed |
| remap_start_kb | output | 14 | Remap start in KB |
| addr_hit | output | 1 | Lookup address is inside the upper area |
| addr_rd_dram | output | 1 | Read source for the lookup address |
| addr_wr | output | 2 | Write target for the lookup address |

## Verification
Several relations are checked whenever the inputs are known:
- no reserved write code appears;
- a DRAM read never pairs with a bus write;
- the bitmap agrees with the per-block attributes;
- remap never coexists with a shadowed block or too much memory;
- the lookup port agrees with the block it selects.

Only the bench scenarios can show that each block follows the correct register bits and honours the priority order. The same holds for the F mode and the exact remap boundary at 8192 KB. They also cover lookups at the block edges (0xBFFFF, 0xC0000, 0xEFFFF, 0xF0000, 0xFFFFF).

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

  typedef enum logic [1:0] {
    WR_BUS  = 2'b00,
    WR_DRAM = 2'b01,
    WR_DROP = 2'b10
  } wr_tgt_e;

  typedef struct packed {
    logic    rd_dram;
    wr_tgt_e wr;
  } region_attr_t;

  localparam region_attr_t ATTR_OPEN = '{rd_dram: 1'b0, wr: WR_BUS};

  // Priority: master+enable, then write-internal, then open bus
  function automatic region_attr_t resolve_block(input logic master, input logic en,
                                                 input logic wp, input logic wint);
    region_attr_t a;
    if (master && en) begin
      a.rd_dram = 1'b1;
      a.wr      = wp ? WR_DROP : WR_DRAM;
    end else if (wint) begin
      a.rd_dram = 1'b0;
      a.wr      = WR_DRAM;
    end else begin
      a = ATTR_OPEN;
    end
    return a;
  endfunction

  function automatic region_attr_t resolve_top(input logic bus_read_mode);
    region_attr_t a;
    a.rd_dram = ~bus_read_mode;
    a.wr      = bus_read_mode ? WR_DRAM : WR_DROP;
    return a;
  endfunction

  function automatic logic touches_dram(input region_attr_t a);
    return a.rd_dram || (a.wr == WR_DRAM);
  endfunction

endpackage

// File: rtl/shadow_blk_resolve.sv
module shadow_blk_resolve
  import shadow_dec_pkg::*;
(
  input  logic         master,
  input  logic         en,
  input  logic         wp,
  input  logic         wint,
  output region_attr_t attr
);
  assign attr = resolve_block(master, en, wp, wint);
endmodule

// File: rtl/shadow_group.sv
module shadow_group
  import shadow_dec_pkg::*;
#(
  parameter int NBLK = 4
) (
  input  logic                    master,
  input  logic                    wp,
  input  logic                    wint,
  input  logic [NBLK-1:0]         en,
  output region_attr_t [NBLK-1:0] attrs
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    shadow_blk_resolve u_res (
      .master (master),
      .en     (en[i]),
      .wp     (wp),
      .wint   (wint),
      .attr   (attrs[i])
    );
  end
endmodule

// File: rtl/shadow_remap.sv
module shadow_remap #(
  parameter int MEM_KB_W     = 16,
  parameter int MEM_LIMIT_KB = 8192,
  parameter int START_W      = 14
) (
  input  logic [7:0]          cfg_remap,
  input  logic [MEM_KB_W-1:0] mem_size_kb,
  input  logic                any_low_shadow,
  output logic                remap_en,
  output logic [START_W-1:0]  remap_start_kb
);
  logic mem_small;
  logic start_nz;

  assign mem_small = (mem_size_kb <= MEM_KB_W'(MEM_LIMIT_KB));
  assign start_nz  = |cfg_remap[3:0];
  assign remap_en  = mem_small && !any_low_shadow && start_nz && cfg_remap[4];
  assign remap_start_kb = remap_en ? START_W'({cfg_remap[3:0], 10'b0}) : '0;
endmodule

// File: rtl/shadow_lookup.sv
module shadow_lookup
  import shadow_dec_pkg::*;
#(
  parameter int NBLK     = 12,
  parameter int ADDR_W   = 20,
  parameter int BLK_SH   = 14,
  parameter int BASE_IDX = 48
) (
  input  logic [ADDR_W-1:0]       addr,
  input  region_attr_t [NBLK-1:0] blk_attrs,
  input  region_attr_t            f_attr,
  output logic                    hit,
  output region_attr_t            attr
);
  localparam int IDX_W = ADDR_W - BLK_SH;
  localparam int KW    = $clog2(NBLK);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic [KW-1:0]    k;

  assign idx = addr[ADDR_W-1:BLK_SH];
  assign rel = idx - IDX_W'(BASE_IDX);
  assign k   = rel[KW-1:0];

  always_comb begin
    if (idx < IDX_W'(BASE_IDX)) begin
      hit  = 1'b0;
      attr = ATTR_OPEN;
    end else if (idx >= IDX_W'(BASE_IDX + NBLK)) begin
      hit  = 1'b1;
      attr = f_attr;
    end else begin
      hit  = 1'b1;
      attr = blk_attrs[k];
    end
  end
endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
  import shadow_dec_pkg::*;
#(
  parameter int C_BLOCKS     = 4,
  parameter int DE_BLOCKS    = 8,
  parameter int MEM_KB_W     = 16,
  parameter int MEM_LIMIT_KB = 8192,
  parameter int ADDR_W       = 20,
  localparam int NBLK        = C_BLOCKS + DE_BLOCKS,
  localparam int MAP_W       = NBLK + 4,
  localparam int START_W     = 14
) (
  input  logic [7:0]          cfg_remap,
  input  logic [7:0]          cfg_main,
  input  logic [7:0]          cfg_de_en,
  input  logic [7:0]          cfg_c,
  input  logic [MEM_KB_W-1:0] mem_size_kb,
  input  logic [ADDR_W-1:0]   lookup_addr,
  output logic [NBLK-1:0]     blk_rd_dram,
  output logic [2*NBLK-1:0]   blk_wr,
  output logic                f_rd_dram,
  output logic [1:0]          f_wr,
  output logic [MAP_W-1:0]    shadow_map,
  output logic                remap_en,
  output logic [START_W-1:0]  remap_start_kb,
  output logic                addr_hit,
  output logic                addr_rd_dram,
  output logic [1:0]          addr_wr
);
  localparam int HALF = DE_BLOCKS / 2;

  region_attr_t [NBLK-1:0]      all_attr;
  region_attr_t [C_BLOCKS-1:0]  c_attr;
  region_attr_t [HALF-1:0]      d_attr;
  region_attr_t [HALF-1:0]      e_attr;
  region_attr_t                 f_attr;
  region_attr_t                 look_attr;
  logic                         wint;
  logic                         any_low_shadow;

  assign wint = cfg_c[6];

  shadow_group #(.NBLK(C_BLOCKS)) u_c (
    .master (cfg_c[4]), .wp (cfg_c[5]), .wint (wint),
    .en (cfg_c[C_BLOCKS-1:0]), .attrs (c_attr)
  );
  shadow_group #(.NBLK(HALF)) u_d (
    .master (cfg_main[6]), .wp (cfg_main[4]), .wint (wint),
    .en (cfg_de_en[HALF-1:0]), .attrs (d_attr)
  );
  shadow_group #(.NBLK(HALF)) u_e (
    .master (cfg_main[5]), .wp (cfg_main[3]), .wint (wint),
    .en (cfg_de_en[DE_BLOCKS-1:HALF]), .attrs (e_attr)
  );

  assign all_attr = {e_attr, d_attr, c_attr};
  assign f_attr   = resolve_top(cfg_main[7]);
  assign f_rd_dram = f_attr.rd_dram;
  assign f_wr      = f_attr.wr;

  for (genvar k = 0; k < NBLK; k++) begin : g_out
    assign blk_rd_dram[k]     = all_attr[k].rd_dram;
    assign blk_wr[2*k +: 2]   = all_attr[k].wr;
    assign shadow_map[k]      = touches_dram(all_attr[k]);
  end
  assign shadow_map[MAP_W-1:NBLK] = '1;

  assign any_low_shadow = |shadow_map[NBLK-1:0];

  shadow_remap #(
    .MEM_KB_W (MEM_KB_W), .MEM_LIMIT_KB (MEM_LIMIT_KB), .START_W (START_W)
  ) u_remap (
    .cfg_remap (cfg_remap), .mem_size_kb (mem_size_kb),
    .any_low_shadow (any_low_shadow),
    .remap_en (remap_en), .remap_start_kb (remap_start_kb)
  );

  shadow_lookup #(
    .NBLK (NBLK), .ADDR_W (ADDR_W), .BLK_SH (14), .BASE_IDX (48)
  ) u_look (
    .addr (lookup_addr), .blk_attrs (all_attr), .f_attr (f_attr),
    .hit (addr_hit), .attr (look_attr)
  );
  assign addr_rd_dram = look_attr.rd_dram;
  assign addr_wr      = look_attr.wr;
endmodule

// File: rtl/shadow_region_decoder_chk.sv
module shadow_region_decoder_chk #(
  parameter int NBLK         = 12,
  parameter int MEM_KB_W     = 16,
  parameter int MEM_LIMIT_KB = 8192,
  parameter int ADDR_W       = 20
) (
  input logic [7:0]          cfg_remap,
  input logic [7:0]          cfg_main,
  input logic [7:0]          cfg_de_en,
  input logic [7:0]          cfg_c,
  input logic [MEM_KB_W-1:0] mem_size_kb,
  input logic [ADDR_W-1:0]   lookup_addr,
  input logic [NBLK-1:0]     blk_rd_dram,
  input logic [2*NBLK-1:0]   blk_wr,
  input logic                f_rd_dram,
  input logic [1:0]          f_wr,
  input logic [NBLK+3:0]     shadow_map,
  input logic                remap_en,
  input logic                addr_hit,
  input logic                addr_rd_dram,
  input logic [1:0]          addr_wr
);
  logic known;
  assign known = !$isunknown({cfg_remap, cfg_main, cfg_de_en, cfg_c, mem_size_kb, lookup_addr});

  always_comb begin
    if (known) begin
      AST_F_MODE: assert ((f_rd_dram && f_wr == 2'b10) || (!f_rd_dram && f_wr == 2'b01)); // R1
      for (int k = 0; k < NBLK; k++) begin
        AST_NO_RESERVED_WR: assert (blk_wr[2*k +: 2] != 2'b11); // R2
        AST_DRAM_READ_NO_BUS_WR: assert (!blk_rd_dram[k] || blk_wr[2*k +: 2] != 2'b00); // R3
        AST_MAP_AGREES: assert (shadow_map[k] == (blk_rd_dram[k] || blk_wr[2*k +: 2] == 2'b01)); // R7
      end
      AST_MAP_TOP_SET: assert (&shadow_map[NBLK+3:NBLK]); // R7
      AST_REMAP_CLEAN: assert (!remap_en || (shadow_map[NBLK-1:0] == '0
                              && mem_size_kb <= MEM_KB_W'(MEM_LIMIT_KB))); // R8
      AST_LOOKUP_MISS_OPEN: assert (addr_hit || (!addr_rd_dram && addr_wr == 2'b00)); // R10
    end
  end
endmodule

bind shadow_region_decoder shadow_region_decoder_chk #(
  .NBLK (12), .MEM_KB_W (16), .MEM_LIMIT_KB (8192), .ADDR_W (20)
) chk_i (
  .cfg_remap (cfg_remap), .cfg_main (cfg_main), .cfg_de_en (cfg_de_en),
  .cfg_c (cfg_c), .mem_size_kb (mem_size_kb), .lookup_addr (lookup_addr),
  .blk_rd_dram (blk_rd_dram), .blk_wr (blk_wr), .f_rd_dram (f_rd_dram),
  .f_wr (f_wr), .shadow_map (shadow_map), .remap_en (remap_en),
  .addr_hit (addr_hit), .addr_rd_dram (addr_rd_dram), .addr_wr (addr_wr)
);

// File: tb/shadow_region_decoder_tb_top.sv
module shadow_region_decoder_tb_top;
  localparam int NB = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  r1, r2, r3, r6;
  logic [15:0] mem;
  logic [19:0] addr;
  logic [NB-1:0]   blk_rd_dram;
  logic [2*NB-1:0] blk_wr;
  logic            f_rd_dram;
  logic [1:0]      f_wr;
  logic [15:0]     shadow_map;
  logic            remap_en;
  logic [13:0]     remap_start_kb;
  logic            addr_hit, addr_rd_dram;
  logic [1:0]      addr_wr;

  int n_chk = 0;
  int n_bad = 0;

  shadow_region_decoder dut_i (
    .cfg_remap (r1), .cfg_main (r2), .cfg_de_en (r3), .cfg_c (r6),
    .mem_size_kb (mem), .lookup_addr (addr),
    .blk_rd_dram (blk_rd_dram), .blk_wr (blk_wr),
    .f_rd_dram (f_rd_dram), .f_wr (f_wr), .shadow_map (shadow_map),
    .remap_en (remap_en), .remap_start_kb (remap_start_kb),
    .addr_hit (addr_hit), .addr_rd_dram (addr_rd_dram), .addr_wr (addr_wr)
  );

  // {rd, wr[1:0]}: rd 1=DRAM; wr 00 bus, 01 DRAM, 10 dropped
  function automatic logic [2:0] ref_blk(int k, logic [7:0] s2, logic [7:0] s3, logic [7:0] s6);
    logic m, e, w;
    if (k < 4)      begin m = s6[4]; w = s6[5]; e = s6[k];   end
    else if (k < 8) begin m = s2[6]; w = s2[4]; e = s3[k-4]; end
    else            begin m = s2[5]; w = s2[3]; e = s3[k-4]; end
    casez ({m & e, w, s6[6]})
      3'b11?:  return 3'b110;
      3'b10?:  return 3'b101;
      3'b0?1:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] ref_f(logic [7:0] s2);
    return s2[7] ? 3'b001 : 3'b110;
  endfunction

  function automatic string blk_tag(int k, logic [7:0] s2, logic [7:0] s3, logic [7:0] s6);
    logic [2:0] v = ref_blk(k, s2, s3, s6);
    if (v[2])            return "R3/R4";
    else if (v == 3'b001) return "R5";
    else                 return "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s r1=%h r2=%h r3=%h r6=%h mem=%0d addr=%h act=%h exp=%h",
               tag, r1, r2, r3, r6, mem, addr, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] a1, logic [7:0] a2, logic [7:0] a3, logic [7:0] a6,
                       logic [15:0] m, logic [19:0] ad);
    logic [15:0] emap;
    logic        een;
    logic [2:0]  elook;
    @(negedge clk);
    r1 = a1; r2 = a2; r3 = a3; r6 = a6; mem = m; addr = ad;
    #2;
    emap = 16'hF000;
    for (int k = 0; k < NB; k++) begin
      logic [2:0] e = ref_blk(k, r2, r3, r6);
      check({blk_tag(k, r2, r3, r6), " R2 block"}, {blk_rd_dram[k], blk_wr[2*k +: 2]}, e);
      emap[k] = e[2] | (e[1:0] == 2'b01);
    end
    check("R1 F region", {f_rd_dram, f_wr}, ref_f(r2));
    check("R7 shadow map", shadow_map, emap);
    een = (mem <= 16'd8192) && (emap[11:0] == 12'h000) && (r1[3:0] != 4'h0) && r1[4];
    check("R8 remap enable", remap_en, een);
    check("R9 remap start", remap_start_kb, een ? 32'(r1[3:0]) * 1024 : 0);
    if (addr < 20'hC0000)      elook = 3'b000;
    else if (addr >= 20'hF0000) elook = ref_f(r2);
    else                       elook = ref_blk(int'((addr - 20'hC0000) >> 14), r2, r3, r6);
    check("R10 lookup", {addr_hit, addr_rd_dram, addr_wr}, {addr >= 20'hC0000, elook});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    r1 = 0; r2 = 0; r3 = 0; r6 = 0; mem = 0; addr = 0;
    // Cleared controls: blocks open, F reads DRAM, drops writes (R1 R6)
    apply(8'h00, 8'h00, 8'h00, 8'h00, 16'd640, 20'h00000);
    // Every enable on, no protect (R3 R4)
    apply(8'h00, 8'h60, 8'hFF, 8'h1F, 16'd4096, 20'hC0000);
    // Protect on every group (R3 R4)
    apply(8'h00, 8'hF8, 8'hFF, 8'h3F, 16'd4096, 20'hEFFFF);
    // Only D master: E blocks fall back (R4)
    apply(8'h00, 8'h40, 8'hFF, 8'h00, 16'd4096, 20'hE0000);
    // Write-internal with masters off (R5)
    apply(8'h00, 8'h80, 8'hFF, 8'h4F, 16'd4096, 20'hF0000);
    // Remap boundary at 8192 and 8193 KB (R8 R9)
    apply(8'h1F, 8'h00, 8'h00, 8'h00, 16'd8192, 20'hFFFFF);
    apply(8'h1F, 8'h00, 8'h00, 8'h00, 16'd8193, 20'hBFFFF);
    apply(8'h10, 8'h00, 8'h00, 8'h00, 16'd1024, 20'hCFFFF);
    apply(8'h05, 8'h00, 8'h00, 8'h00, 16'd1024, 20'hD0000);
    // One shadowed block blocks remap (R8)
    apply(8'h13, 8'h20, 8'h80, 8'h00, 16'd2048, 20'hEC000);
    for (int v = 0; v < 2000; v++) begin
      logic [7:0]  x2, x3, x6;
      logic [15:0] xm;
      x2 = 8'($urandom); x3 = 8'($urandom); x6 = 8'($urandom);
      if ($urandom_range(0, 2) == 0) begin x2[6:5] = 2'b00; x6[6] = 1'b0; x6[4] = 1'b0; end
      case ($urandom_range(0, 3))
        0: xm = 16'd8192;
        1: xm = 16'd8193;
        default: xm = 16'($urandom_range(0, 16384));
      endcase
      apply(8'($urandom), x2, x3, x6, xm, 20'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule